// File: doc/BRIEF.md
# Command Queue Register Block

This block is the device-side register file through which a host hands commands to a storage controller and collects the results. A host writes the 32-bit bus address of a command descriptor to a request port, and that value enters an inbound FIFO. The controller's firmware takes entries from the inbound FIFO through a small internal interface. When it finishes a command, it pushes a completion tag into an outbound FIFO. The host collects tags one at a time by reading a reply port. When no reply is waiting, that read returns an all-ones sentinel instead of stalling the bus.

An interrupt line tells the host that replies are waiting. It is gated by a mask register with inverted sense: the reply interrupt is suppressed while mask bit 3 is set, and it is enabled when that bit is written clear. A status register shows whether a reply is pending, whatever the mask holds. A scratchpad register shows the firmware-ready word a fixed number of cycles after reset. A doorbell register holds a host-written value for the firmware to see. A sticky flag records any request that was dropped because the inbound FIFO was full.

Register accesses are single-cycle strobes on a plain bus. Read data returns one cycle after the read strobe, marked by a valid pulse.

Top module: `cmdq_regblk`

## Requirements
- R1: A host write to byte offset 0x40 pushes the 32-bit write data into the inbound FIFO. The firmware side then sees the entries in arrival order on `fw_req_data` while `fw_req_valid` is high, and `fw_req_pop` removes the head entry.
- R2: A host read of offset 0x44 returns the oldest completion tag on `reg_rdata`, with `reg_rvalid` high, one cycle after the read strobe, and removes that tag from the outbound FIFO.
- R3: A read of offset 0x44 while the outbound FIFO is empty returns 0xFFFFFFFF and leaves the FIFO unchanged.
- R4: The interrupt mask register at offset 0x34 resets to 0x00000008 and reads back the last value written. Bit 3 set disables the reply interrupt; bit 3 clear enables it.
- R5: `irq_o` is high exactly while the outbound FIFO holds at least one tag and mask bit 3 is clear. The status register at offset 0x30 reads 0x00000008 while a tag is held and 0 otherwise, whatever the mask holds.
- R6: The scratchpad at offset 0xB0 reads 0 until READY_CYCLES clock edges after reset release, and 0xFFFF0000 from then on. Host writes to it have no effect.
- R7: A request write while the inbound FIFO holds REQ_DEPTH entries is dropped and sets bit 0 of the register at offset 0x50. That bit stays set until reset.
- R8: A read of offset 0x40 returns the last value written there and does not push or pop anything.
- R9: The doorbell register at offset 0x20 holds the last value the host wrote there. It reads back on the bus and is driven on `fw_doorbell`.
- R10: `fw_rsp_ready` is low while the outbound FIFO holds RSP_DEPTH tags. A firmware push in that state is dropped.
- R11: A read of any offset not listed above returns 0, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 8 | Host byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_o | output | 1 | Reply interrupt |
| fw_doorbell | output | 32 | Doorbell value for the firmware |
| fw_req_valid | output | 1 | Inbound FIFO not empty |
| fw_req_data | output | 32 | Head of the inbound FIFO |
| fw_req_pop | input | 1 | Firmware removes the inbound head |
| fw_rsp_push | input | 1 | Firmware pushes a completion tag |
| fw_rsp_tag | input | 32 | Completion tag to push |
| fw_rsp_ready | output | 1 | Outbound FIFO not full |

## Verification
A wrong FIFO pointer or count shows up as a wrong tag, or a sentinel in place of a tag, on the very next reply read. It also shows up as a missing or stuck `irq_o` in the cycle after the push or pop. A corrupted inbound FIFO shows up on `fw_req_data` as soon as the firmware side drains it, as an out-of-order or lost address. A wrong overflow decision shows up as one entry too many or too few in that drain, and in the sticky bit at the next status read. Mask and scratchpad faults show up within one access, as a wrong read-back value or a wrong interrupt level.

// File: rtl/cmdq_pkg.sv
`timescale 1ns/1ps
package cmdq_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_DOORBELL = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_STATUS   = 8'h30;
    localparam logic [ADDR_W-1:0] OFF_MASK     = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_REQ      = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_RSP      = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_OVF      = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_SCRATCH  = 8'hB0;

    localparam logic [DATA_W-1:0] EMPTY_WORD = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] READY_WORD = 32'hFFFF_0000;
    localparam logic [DATA_W-1:0] MASK_RESET = 32'h0000_0008;
    localparam int IRQ_BIT = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DOORBELL,
        SEL_STATUS,
        SEL_MASK,
        SEL_REQ,
        SEL_RSP,
        SEL_OVF,
        SEL_SCRATCH
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] off);
        case (off)
            OFF_DOORBELL: return SEL_DOORBELL;
            OFF_STATUS:   return SEL_STATUS;
            OFF_MASK:     return SEL_MASK;
            OFF_REQ:      return SEL_REQ;
            OFF_RSP:      return SEL_RSP;
            OFF_OVF:      return SEL_OVF;
            OFF_SCRATCH:  return SEL_SCRATCH;
            default:      return SEL_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] flag_word(input logic flag, input int pos);
        logic [DATA_W-1:0] w;
        w = '0;
        w[pos] = flag;
        return w;
    endfunction
endpackage

// File: rtl/cmdq_fifo.sv
`timescale 1ns/1ps
module cmdq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_q;
    logic             push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/cmdq_ready_timer.sv
`timescale 1ns/1ps
module cmdq_ready_timer #(
    parameter int CYCLES = 1000,
    localparam int TW = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    logic [TW-1:0] cnt_q;
    logic          ready_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            cnt_q <= cnt_q + TW'(1);
            if (cnt_q == TW'(CYCLES - 1)) ready_q <= 1'b1;
        end
    end

    assign ready = ready_q;
endmodule

// File: rtl/cmdq_regblk.sv
`timescale 1ns/1ps
module cmdq_regblk
    import cmdq_pkg::*;
#(
    parameter int REQ_DEPTH    = 8,
    parameter int RSP_DEPTH    = 8,
    parameter int READY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq_o,
    output logic [DATA_W-1:0] fw_doorbell,
    output logic              fw_req_valid,
    output logic [DATA_W-1:0] fw_req_data,
    input  logic              fw_req_pop,
    input  logic              fw_rsp_push,
    input  logic [DATA_W-1:0] fw_rsp_tag,
    output logic              fw_rsp_ready
);
    localparam int REQ_CW = $clog2(REQ_DEPTH + 1);
    localparam int RSP_CW = $clog2(RSP_DEPTH + 1);

    reg_sel_e sel;
    logic     req_push, req_full, req_empty;
    logic     rsp_pop, rsp_full, rsp_empty;
    logic     fw_ready;
    logic [REQ_CW-1:0] req_count;
    logic [RSP_CW-1:0] rsp_count;
    logic [DATA_W-1:0] rsp_head, rd_mux;
    logic [DATA_W-1:0] doorbell_q, mask_q, last_req_q, rdata_q;
    logic              ovf_q, rvalid_q;

    assign sel      = decode_offset(reg_addr);
    assign req_push = reg_wr && (sel == SEL_REQ);
    assign rsp_pop  = reg_rd && (sel == SEL_RSP) && !rsp_empty;

    cmdq_fifo #(.WIDTH(DATA_W), .DEPTH(REQ_DEPTH)) u_req_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (req_push),
        .wdata (reg_wdata),
        .pop   (fw_req_pop),
        .rdata (fw_req_data),
        .full  (req_full),
        .empty (req_empty),
        .count (req_count)
    );

    cmdq_fifo #(.WIDTH(DATA_W), .DEPTH(RSP_DEPTH)) u_rsp_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fw_rsp_push),
        .wdata (fw_rsp_tag),
        .pop   (rsp_pop),
        .rdata (rsp_head),
        .full  (rsp_full),
        .empty (rsp_empty),
        .count (rsp_count)
    );

    cmdq_ready_timer #(.CYCLES(READY_CYCLES)) u_ready (
        .clk   (clk),
        .rst   (rst),
        .ready (fw_ready)
    );

    always_comb begin
        case (sel)
            SEL_DOORBELL: rd_mux = doorbell_q;
            SEL_STATUS:   rd_mux = flag_word(!rsp_empty, IRQ_BIT);
            SEL_MASK:     rd_mux = mask_q;
            SEL_REQ:      rd_mux = last_req_q;
            SEL_RSP:      rd_mux = rsp_empty ? EMPTY_WORD : rsp_head;
            SEL_OVF:      rd_mux = flag_word(ovf_q, 0);
            SEL_SCRATCH:  rd_mux = fw_ready ? READY_WORD : '0;
            default:      rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            doorbell_q <= '0;
            mask_q     <= MASK_RESET;
            last_req_q <= '0;
            ovf_q      <= 1'b0;
            rdata_q    <= '0;
            rvalid_q   <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (sel)
                    SEL_DOORBELL: doorbell_q <= reg_wdata;
                    SEL_MASK:     mask_q     <= reg_wdata;
                    SEL_REQ:      last_req_q <= reg_wdata;
                    default:      ;
                endcase
            end
            if (req_push && req_full) ovf_q <= 1'b1;
            rvalid_q <= reg_rd;
            if (reg_rd) rdata_q <= rd_mux;
        end
    end

    assign reg_rdata    = rdata_q;
    assign reg_rvalid   = rvalid_q;
    assign irq_o        = !rsp_empty && !mask_q[IRQ_BIT];
    assign fw_doorbell  = doorbell_q;
    assign fw_req_valid = !req_empty;
    assign fw_rsp_ready = !rsp_full;
endmodule

// File: rtl/cmdq_regblk_chk.sv
`timescale 1ns/1ps
module cmdq_regblk_chk
    import cmdq_pkg::*;
#(
    parameter int REQ_CW = 4,
    parameter int RSP_CW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              reg_rvalid,
    input logic              irq_o,
    input logic              fw_req_pop,
    input logic              fw_rsp_push,
    input logic              fw_rsp_ready,
    input logic              req_full,
    input logic [REQ_CW-1:0] req_count,
    input logic              rsp_empty,
    input logic [RSP_CW-1:0] rsp_count,
    input logic              ovf_q
);
    logic rd_rsp;
    assign rd_rsp = reg_rd && (reg_addr == OFF_RSP);

    p_rvalid_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

    p_pop_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_rsp && !rsp_empty && !fw_rsp_push) |=> (rsp_count == $past(rsp_count) - RSP_CW'(1)));

    p_sentinel_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_rsp && rsp_empty) |=> (reg_rdata == EMPTY_WORD));

    p_empty_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_rsp && rsp_empty && !fw_rsp_push) |=> rsp_empty);

    p_mask_off_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_MASK && reg_wdata[IRQ_BIT]) |=> !irq_o);

    p_mask_on_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_MASK && !reg_wdata[IRQ_BIT] && !rsp_empty && !rd_rsp) |=> irq_o);

    p_scratch_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == OFF_SCRATCH) |=> (reg_rdata == '0 || reg_rdata == READY_WORD));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_REQ && req_full && !fw_req_pop) |=> (req_count == $past(req_count) && ovf_q));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    p_rsp_full_r10: assert property (@(posedge clk) disable iff (rst)
        (fw_rsp_push && !fw_rsp_ready && !rd_rsp) |=> $stable(rsp_count));
endmodule

bind cmdq_regblk cmdq_regblk_chk #(.REQ_CW(REQ_CW), .RSP_CW(RSP_CW)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .reg_rvalid   (reg_rvalid),
    .irq_o        (irq_o),
    .fw_req_pop   (fw_req_pop),
    .fw_rsp_push  (fw_rsp_push),
    .fw_rsp_ready (fw_rsp_ready),
    .req_full     (req_full),
    .req_count    (req_count),
    .rsp_empty    (rsp_empty),
    .rsp_count    (rsp_count),
    .ovf_q        (ovf_q)
);

// File: tb/cmdq_regblk_tb_top.sv
`timescale 1ns/1ps
module cmdq_regblk_tb_top;
    import cmdq_pkg::*;

    localparam int DEPTH = 8;
    localparam int RDY   = 40;

    logic              clk = 1'b0;
    logic              rst;
    logic              reg_wr, reg_rd;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] reg_wdata, reg_rdata;
    logic              reg_rvalid, irq_o;
    logic [DATA_W-1:0] fw_doorbell, fw_req_data, fw_rsp_tag;
    logic              fw_req_valid, fw_req_pop, fw_rsp_push, fw_rsp_ready;

    int n_checks = 0;
    int n_fail   = 0;
    logic drain_en = 1'b0;
    logic [DATA_W-1:0] exp_req[$];
    logic [DATA_W-1:0] exp_rsp[$];

    always #2.5 clk = ~clk;

    cmdq_regblk #(.REQ_DEPTH(DEPTH), .RSP_DEPTH(DEPTH), .READY_CYCLES(RDY)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq_o(irq_o),
        .fw_doorbell(fw_doorbell), .fw_req_valid(fw_req_valid), .fw_req_data(fw_req_data),
        .fw_req_pop(fw_req_pop), .fw_rsp_push(fw_rsp_push), .fw_rsp_tag(fw_rsp_tag),
        .fw_rsp_ready(fw_rsp_ready)
    );

    task automatic check32(input string req, input string what,
                           input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        check32("R2", "rvalid", {31'b0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    // driver: request side
    task automatic send_req(input logic [DATA_W-1:0] d, input bit accept);
        if (accept) exp_req.push_back(d);
        bus_write(OFF_REQ, d);
    endtask

    // driver: firmware completion side
    task automatic fw_push(input logic [DATA_W-1:0] t, input bit accept);
        if (accept) exp_rsp.push_back(t);
        fw_rsp_push = 1'b1; fw_rsp_tag = t;
        @(negedge clk);
        fw_rsp_push = 1'b0;
    endtask

    // host reply read compared with the reply scoreboard
    task automatic host_pop(input string req);
        logic [DATA_W-1:0] d, e;
        e = (exp_rsp.size() > 0) ? exp_rsp.pop_front() : EMPTY_WORD;
        bus_read(OFF_RSP, d);
        check32(req, "reply port", d, e);
    endtask

    // monitor: firmware drains the inbound FIFO and compares against the scoreboard
    initial begin
        fw_req_pop = 1'b0;
        forever begin
            @(negedge clk);
            if (drain_en && fw_req_valid) begin
                if (exp_req.size() > 0) check32("R1", "inbound head", fw_req_data, exp_req.pop_front());
                else check32("R1", "unexpected inbound entry", fw_req_data, 32'hx);
                fw_req_pop = 1'b1;
            end else begin
                fw_req_pop = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        fw_rsp_push = 0; fw_rsp_tag = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state
        check32("R5", "irq after reset", {31'b0, irq_o}, 32'd0);
        check32("R1", "req valid after reset", {31'b0, fw_req_valid}, 32'd0);
        check32("R10", "rsp ready after reset", {31'b0, fw_rsp_ready}, 32'd1);
        bus_read(OFF_MASK, d);    check32("R4", "mask reset", d, 32'h8);
        bus_read(OFF_SCRATCH, d); check32("R6", "scratch before ready", d, 32'h0);

        // doorbell
        bus_write(OFF_DOORBELL, 32'hA5A5_0001);
        bus_read(OFF_DOORBELL, d); check32("R9", "doorbell readback", d, 32'hA5A5_0001);
        check32("R9", "doorbell output", fw_doorbell, 32'hA5A5_0001);

        // unmapped offsets
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, d); check32("R11", "unmapped read", d, 32'h0);
        bus_write(8'h24, 32'hDEAD_BEEF);
        bus_read(OFF_DOORBELL, d); check32("R11", "unmapped write leaves doorbell", d, 32'hA5A5_0001);
        bus_read(OFF_MASK, d);     check32("R11", "unmapped write leaves mask", d, 32'h8);

        // empty reply port
        host_pop("R3");
        host_pop("R3");
        bus_read(OFF_STATUS, d); check32("R5", "status empty", d, 32'h0);
        check32("R3", "irq after empty read", {31'b0, irq_o}, 32'd0);

        // requests in order
        drain_en = 1'b1;
        send_req(32'h1000_0040, 1);
        send_req(32'h2000_0080, 1);
        send_req(32'h3000_00C0, 1);
        repeat (6) @(negedge clk);
        check32("R1", "inbound all drained", exp_req.size(), 32'd0);

        // request port read-back, no push
        bus_read(OFF_REQ, d); check32("R8", "request readback", d, 32'h3000_00C0);
        repeat (3) @(negedge clk);
        check32("R8", "no push from read", {31'b0, fw_req_valid}, 32'd0);

        // replies with mask set then cleared
        fw_push(32'h0000_0011, 1);
        fw_push(32'h0000_0022, 1);
        check32("R5", "irq masked", {31'b0, irq_o}, 32'd0);
        bus_read(OFF_STATUS, d); check32("R5", "status pending while masked", d, 32'h8);
        bus_write(OFF_MASK, 32'h0);
        check32("R4", "irq enabled by zero", {31'b0, irq_o}, 32'd1);
        bus_read(OFF_MASK, d); check32("R4", "mask readback 0", d, 32'h0);
        host_pop("R2");
        check32("R5", "irq with one left", {31'b0, irq_o}, 32'd1);
        host_pop("R2");
        check32("R5", "irq after drain", {31'b0, irq_o}, 32'd0);
        host_pop("R3");

        // disable with pending data
        fw_push(32'h0000_0033, 1);
        check32("R5", "irq on push", {31'b0, irq_o}, 32'd1);
        bus_write(OFF_MASK, 32'h8);
        check32("R4", "irq disabled by 0x08", {31'b0, irq_o}, 32'd0);
        bus_read(OFF_STATUS, d); check32("R5", "status independent of mask", d, 32'h8);
        host_pop("R2");

        // inbound overflow
        drain_en = 1'b0;
        bus_read(OFF_OVF, d); check32("R7", "overflow clear", d, 32'h0);
        for (int i = 0; i < DEPTH; i++) send_req(32'hC000_0000 + i, 1);
        send_req(32'hBAD0_0000, 0);
        bus_read(OFF_OVF, d); check32("R7", "overflow set", d, 32'h1);
        drain_en = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        check32("R7", "drained exactly depth", exp_req.size(), 32'd0);
        check32("R7", "inbound empty after drain", {31'b0, fw_req_valid}, 32'd0);
        bus_read(OFF_OVF, d); check32("R7", "overflow sticky", d, 32'h1);

        // outbound full
        bus_write(OFF_MASK, 32'h0);
        for (int i = 0; i < DEPTH; i++) fw_push(32'h0000_0A00 + i, 1);
        check32("R10", "rsp ready low when full", {31'b0, fw_rsp_ready}, 32'd0);
        fw_push(32'h0000_0BAD, 0);
        fw_push(32'h0000_0BAE, 0);
        for (int i = 0; i < DEPTH; i++) host_pop("R10");
        host_pop("R3");
        check32("R10", "rsp ready after drain", {31'b0, fw_rsp_ready}, 32'd1);
        check32("R5", "irq after full drain", {31'b0, irq_o}, 32'd0);

        // scratchpad ready
        repeat (RDY + 5) @(negedge clk);
        bus_read(OFF_SCRATCH, d); check32("R6", "scratch ready", d, READY_WORD);
        bus_write(OFF_SCRATCH, 32'h0);
        bus_read(OFF_SCRATCH, d); check32("R6", "scratch write ignored", d, READY_WORD);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule